// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two single-ended USB data lines into received packet bytes for a low-speed link. The core clock runs at a fixed multiple of the bit rate, 11 clocks per bit by default. The line pins are registered once. A bit timer re-centres on every line transition, so the block keeps sampling near the middle of each bit while the transmitter's clock is up to about one percent off.

While idle, the receiver waits for the line to go from J to K. It then samples the sync field until it sees two K bits in a row. After that it decodes NRZI, drops stuffed bits and shifts bits into bytes, least significant bit first. Each finished byte comes with a one-clock strobe. A single-ended zero at any sample point ends the packet. A byte budget per packet limits the length, and a packet that goes over it is cut off with an overflow pulse. PID and CRC checks are left to the logic downstream.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset every output strobe is low. While idle, only a change of the registered line from J ({dp,dm}=01) to K ({dp,dm}=10) starts reception. SE0 ({dp,dm}=00) and J on the idle line give no output.
- R2: After the start edge, sync ends at the first sample that is K and follows a K sample. The bit sampled next is the first data bit.
- R3: The sync search allows `SYNC_BITS` (default 8) samples. If sample number `SYNC_BITS` does not complete a K-K pair, or any sync sample is SE0, `sync_err` pulses for one clock, no byte is given, and the receiver goes back to idle.
- R4: NRZI decoding gives 1 when a sample equals the previous sample and 0 when it differs. The first data bit is compared with the last sync K.
- R5: Data bits are assembled least significant bit first. When the eighth bit of a byte is taken, `rx_byte` carries the byte and `rx_valid` is high for exactly one clock.
- R6: A sample that follows six consecutive decoded ones is a stuffed bit. It is discarded, and the run counter carries across byte boundaries.
- R7: SE0 at any data sample point ends the packet. This includes the point where a stuffed bit is due. `pkt_end` pulses for one clock, rising at the clock edge that comes HALF+1 edges after the first edge at which the pins show SE0, with HALF = BIT_CLKS/2 rounded down (6 edges at the default).
- R8: Each packet may complete at most `BUF_BYTES` bytes (default 8). The byte after that raises a one-clock `overflow` pulse instead of `rx_valid`. From then until the next SE0 sample nothing is given, not even `pkt_end`, and the packet after that is received normally.
- R9: Every line transition restarts the bit timer, so the next sample falls HALF+1 clocks after the pins change. Packets with one bit in every nine lengthened or shortened by one clock decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, BIT_CLKS per bit period |
| rst | input | 1 | Synchronous active-high reset |
| dp | input | 1 | D+ line sample |
| dm | input | 1 | D- line sample |
| rx_byte | output | 8 | Last assembled byte, valid with `rx_valid` |
| rx_valid | output | 1 | One-clock byte strobe |
| pkt_end | output | 1 | One-clock end-of-packet pulse on SE0 |
| overflow | output | 1 | One-clock pulse when the byte budget is exceeded |
| sync_err | output | 1 | One-clock pulse when no sync end is found |

## Verification
The pins are registered once and transitions are found one clock later. A sample therefore lands HALF+1 clock edges after the pins change, and every strobe is visible from that edge on. The bench records the clock count when it drives SE0 and expects `pkt_end` exactly HALF+2 counts later. Byte, overflow and sync-error pulses are collected by a monitor on the falling clock edge during the packet. They are compared, by count and by value, with an encoder in the bench that applies NRZI and bit stuffing on its own, once the line has returned to idle.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

    // Line state encoded as {dp, dm}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SYNC,
        FR_DATA,
        FR_DRAIN
    } frame_e;

    // Number of equal line samples (decoded ones) that forces a stuffed bit
    localparam int STUFF_RUN = 6;

    function automatic line_e to_line(input logic dp, input logic dm);
        return line_e'({dp, dm});
    endfunction

endpackage

// File: rtl/usb_ls_rx_timing.sv
module usb_ls_rx_timing
    import usb_ls_rx_pkg::*;
#(
    parameter int BIT_CLKS = 11
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  dp,
    input  logic  dm,
    output line_e line,
    output line_e line_prev,
    output logic  edge_seen,
    output logic  sample
);
    localparam int HALF = BIT_CLKS / 2;
    localparam int CW   = $clog2(BIT_CLKS);

    line_e         line_q, line_p;
    logic [CW-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LN_J;
            line_p <= LN_J;
        end else begin
            line_q <= to_line(dp, dm);
            line_p <= line_q;
        end
    end

    assign edge_seen = (line_q != line_p);
    assign sample    = !edge_seen && (ph_q == '0);

    // Bit timer: re-centred on every transition, free running otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= CW'(BIT_CLKS - 1);
        end else if (edge_seen) begin
            ph_q <= CW'(HALF - 1);
        end else if (ph_q == '0) begin
            ph_q <= CW'(BIT_CLKS - 1);
        end else begin
            ph_q <= ph_q - 1'b1;
        end
    end

    assign line      = line_q;
    assign line_prev = line_p;

endmodule

// File: rtl/usb_ls_rx_framer.sv
module usb_ls_rx_framer
    import usb_ls_rx_pkg::*;
#(
    parameter int SYNC_BITS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  line_e line,
    input  line_e line_prev,
    input  logic  edge_seen,
    input  logic  sample,
    input  logic  ovf_hit,
    output logic  sync_done,
    output logic  bit_en,
    output logic  pkt_end,
    output logic  sync_err
);
    localparam int SW = $clog2(SYNC_BITS + 1);

    frame_e        st_q;
    logic [SW-1:0] scnt_q;
    logic          prev_k_q;
    logic          start;

    assign start     = edge_seen && (line_prev == LN_J) && (line == LN_K);
    assign sync_done = (st_q == FR_SYNC) && sample && (line == LN_K) && prev_k_q;
    assign bit_en    = (st_q == FR_DATA) && sample && (line != LN_SE0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= FR_IDLE;
            scnt_q   <= '0;
            prev_k_q <= 1'b0;
            pkt_end  <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            pkt_end  <= 1'b0;
            sync_err <= 1'b0;
            case (st_q)
                FR_IDLE: begin
                    if (start) begin
                        st_q     <= FR_SYNC;
                        scnt_q   <= '0;
                        prev_k_q <= 1'b0;
                    end
                end
                FR_SYNC: begin
                    if (sample) begin
                        if (line == LN_SE0) begin
                            sync_err <= 1'b1;
                            st_q     <= FR_IDLE;
                        end else if (sync_done) begin
                            st_q <= FR_DATA;
                        end else if (scnt_q == SW'(SYNC_BITS - 1)) begin
                            sync_err <= 1'b1;
                            st_q     <= FR_IDLE;
                        end else begin
                            scnt_q   <= scnt_q + 1'b1;
                            prev_k_q <= (line == LN_K);
                        end
                    end
                end
                FR_DATA: begin
                    if (sample) begin
                        if (line == LN_SE0) begin
                            pkt_end <= 1'b1;
                            st_q    <= FR_IDLE;
                        end else if (ovf_hit) begin
                            st_q <= FR_DRAIN;
                        end
                    end
                end
                FR_DRAIN: begin
                    if (sample && (line == LN_SE0)) begin
                        st_q <= FR_IDLE;
                    end
                end
                default: st_q <= FR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/usb_ls_rx_deser.sv
module usb_ls_rx_deser
    import usb_ls_rx_pkg::*;
#(
    parameter int BUF_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       bit_en,
    input  line_e      line,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       overflow,
    output logic       ovf_hit
);
    localparam int BW = $clog2(BUF_BYTES + 1);

    line_e         prev_q;
    logic [2:0]    ones_q;
    logic [2:0]    bcnt_q;
    logic [7:0]    sr_q;
    logic [BW-1:0] budget_q;

    logic       data_bit;
    logic       stuff_slot;
    logic       byte_done;
    logic [7:0] next_sr;

    always_comb begin
        data_bit   = (line == prev_q);
        stuff_slot = (ones_q == 3'(STUFF_RUN));
        next_sr    = {data_bit, sr_q[7:1]};
        byte_done  = bit_en && !stuff_slot && (bcnt_q == 3'd7);
        ovf_hit    = byte_done && (budget_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= LN_K;
            ones_q   <= '0;
            bcnt_q   <= '0;
            sr_q     <= '0;
            budget_q <= BW'(BUF_BYTES);
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            overflow <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            overflow <= 1'b0;
            if (clear) begin
                prev_q   <= line;
                ones_q   <= '0;
                bcnt_q   <= '0;
                budget_q <= BW'(BUF_BYTES);
            end else if (bit_en) begin
                prev_q <= line;
                if (stuff_slot) begin
                    ones_q <= '0;
                end else begin
                    sr_q   <= next_sr;
                    bcnt_q <= bcnt_q + 1'b1;
                    ones_q <= data_bit ? ones_q + 1'b1 : 3'd0;
                    if (byte_done) begin
                        if (budget_q == '0) begin
                            overflow <= 1'b1;
                        end else begin
                            rx_valid <= 1'b1;
                            rx_byte  <= next_sr;
                            budget_q <= budget_q - 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int BIT_CLKS  = 11,
    parameter int BUF_BYTES = 8,
    parameter int SYNC_BITS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dp,
    input  logic       dm,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       pkt_end,
    output logic       overflow,
    output logic       sync_err
);
    line_e line, line_prev;
    logic  edge_seen, sample;
    logic  sync_done, bit_en, ovf_hit;

    usb_ls_rx_timing #(.BIT_CLKS(BIT_CLKS)) u_timing (
        .clk       (clk),
        .rst       (rst),
        .dp        (dp),
        .dm        (dm),
        .line      (line),
        .line_prev (line_prev),
        .edge_seen (edge_seen),
        .sample    (sample)
    );

    usb_ls_rx_framer #(.SYNC_BITS(SYNC_BITS)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .line      (line),
        .line_prev (line_prev),
        .edge_seen (edge_seen),
        .sample    (sample),
        .ovf_hit   (ovf_hit),
        .sync_done (sync_done),
        .bit_en    (bit_en),
        .pkt_end   (pkt_end),
        .sync_err  (sync_err)
    );

    usb_ls_rx_deser #(.BUF_BYTES(BUF_BYTES)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .clear    (sync_done),
        .bit_en   (bit_en),
        .line     (line),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .overflow (overflow),
        .ovf_hit  (ovf_hit)
    );

endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk (
    input logic clk,
    input logic rst,
    input logic dp,
    input logic dm,
    input logic rx_valid,
    input logic pkt_end,
    input logic overflow,
    input logic sync_err
);
    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8
    ovf_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && overflow));

    // R7
    end_on_se0_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> ($past(dp, 2) == 1'b0 && $past(dm, 2) == 1'b0));

    // R7
    end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> !pkt_end);

    // R3
    sync_err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);

    // R3
    sync_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sync_err && (pkt_end || rx_valid)));

endmodule

bind usb_ls_rx usb_ls_rx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dp       (dp),
    .dm       (dm),
    .rx_valid (rx_valid),
    .pkt_end  (pkt_end),
    .overflow (overflow),
    .sync_err (sync_err)
);

// File: tb/test_usb_ls_rx.sv
module test_usb_ls_rx;
    localparam int BIT    = 11;
    localparam int HALF   = BIT / 2;
    localparam int NBUF   = 8;
    localparam int WD_MAX = 150000;
    localparam logic [1:0] LK   = 2'b10;
    localparam logic [1:0] LJ   = 2'b01;
    localparam logic [1:0] LSE0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dp  = 1'b0;
    logic       dm  = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid, pkt_end, overflow, sync_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [7:0] pkt [0:15];
    int         pkt_n;
    logic [7:0] got [0:15];
    int got_n, end_n, ovf_n, serr_n, end_cyc, se0_cyc, bit_idx;

    always #10 clk = ~clk;

    usb_ls_rx i_usb_ls_rx (
        .clk      (clk),
        .rst      (rst),
        .dp       (dp),
        .dm       (dm),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .pkt_end  (pkt_end),
        .overflow (overflow),
        .sync_err (sync_err)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_MAX) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WD_MAX);
            summary();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (got_n < 16) got[got_n] = rx_byte;
                got_n++;
            end
            if (pkt_end) begin
                end_n++;
                end_cyc = cyc;
            end
            if (overflow) ovf_n++;
            if (sync_err) serr_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        got_n = 0; end_n = 0; ovf_n = 0; serr_n = 0; end_cyc = -1; bit_idx = 0;
    endtask

    task automatic emit(input logic [1:0] lv, input int drift);
        int len;
        len = BIT + (((drift != 0) && (bit_idx % 9 == 8)) ? drift : 0);
        {dp, dm} = lv;
        repeat (len) @(negedge clk);
        bit_idx++;
    endtask

    // Encoder: sync, NRZI, stuffing, SE0 end
    task automatic send_pkt(input int drift, input bit drop_last_stuff, input bit bad_sync);
        logic [1:0] lv;
        int ones;
        for (int i = 0; i < 8; i++) begin
            lv = ((i % 2 == 0) || i == 7) ? LK : LJ;
            if (bad_sync && i == 7) lv = LJ;
            emit(lv, drift);
        end
        if (bad_sync) begin
            repeat (4) emit(LJ, 0);
            return;
        end
        ones = 0;
        for (int b = 0; b < pkt_n; b++) begin
            for (int k = 0; k < 8; k++) begin
                if (!pkt[b][k]) lv = (lv == LK) ? LJ : LK;
                emit(lv, drift);
                ones = pkt[b][k] ? ones + 1 : 0;
                if (ones == 6) begin
                    if (!(drop_last_stuff && b == pkt_n - 1 && k == 7)) begin
                        lv = (lv == LK) ? LJ : LK;
                        emit(lv, drift);
                    end
                    ones = 0;
                end
            end
        end
        se0_cyc = cyc;
        emit(LSE0, 0);
        emit(LSE0, 0);
        emit(LJ, 0);
        repeat (20) @(negedge clk);
    endtask

    task automatic check_bytes(input string req);
        chk(got_n == pkt_n, req, got_n, pkt_n);
        for (int i = 0; i < pkt_n && i < got_n && i < 16; i++)
            chk(got[i] == pkt[i], req, int'(got[i]), int'(pkt[i]));
    endtask

    task automatic test_reset();
        chk(rx_valid == 0 && pkt_end == 0 && overflow == 0 && sync_err == 0,
            "R1 reset", {rx_valid, pkt_end, overflow, sync_err}, 0);
    endtask

    task automatic test_single();
        clr_mon();
        pkt_n = 1; pkt[0] = 8'hA5;
        send_pkt(0, 0, 0);
        check_bytes("R4 R5 single byte");
        chk(end_n == 1, "R2 packet end count", end_n, 1);
        chk(end_cyc == se0_cyc + HALF + 2, "R7 pkt_end latency", end_cyc, se0_cyc + HALF + 2);
    endtask

    task automatic test_multi();
        clr_mon();
        pkt_n = 5;
        pkt[0] = 8'h2D; pkt[1] = 8'h00; pkt[2] = 8'h80; pkt[3] = 8'h06; pkt[4] = 8'h31;
        send_pkt(0, 0, 0);
        check_bytes("R4 R5 multi byte");
        chk(end_n == 1 && serr_n == 0, "R2 clean end", end_n, 1);
    endtask

    task automatic test_stuff();
        clr_mon();
        pkt_n = 3; pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E;
        send_pkt(0, 0, 0);
        check_bytes("R6 stuffed run");
        chk(end_n == 1, "R6 end after stuffing", end_n, 1);
    endtask

    task automatic test_stuff_at_end();
        clr_mon();
        pkt_n = 2; pkt[0] = 8'h12; pkt[1] = 8'hFC;
        send_pkt(0, 0, 0);
        check_bytes("R6 trailing stuff bit");
        chk(end_n == 1, "R6 end after trailing stuff", end_n, 1);
        clr_mon();
        send_pkt(0, 1, 0);
        check_bytes("R7 SE0 at stuff slot bytes");
        chk(end_n == 1, "R7 SE0 at stuff slot", end_n, 1);
        chk(end_cyc == se0_cyc + HALF + 2, "R7 latency at stuff slot", end_cyc, se0_cyc + HALF + 2);
    endtask

    task automatic test_overflow();
        clr_mon();
        pkt_n = NBUF + 1;
        for (int i = 0; i < pkt_n; i++) pkt[i] = 8'(8'h41 + i * 7);
        send_pkt(0, 0, 0);
        chk(got_n == NBUF, "R8 bytes before overflow", got_n, NBUF);
        chk(ovf_n == 1, "R8 overflow pulse", ovf_n, 1);
        chk(end_n == 0, "R8 no pkt_end after overflow", end_n, 0);
        clr_mon();
        pkt_n = 2; pkt[0] = 8'h5A; pkt[1] = 8'hC3;
        send_pkt(0, 0, 0);
        check_bytes("R8 recovery after overflow");
        chk(end_n == 1 && ovf_n == 0, "R8 recovery end", end_n, 1);
    endtask

    task automatic test_sync_err();
        clr_mon();
        pkt_n = 0;
        send_pkt(0, 0, 1);
        chk(serr_n == 1, "R3 sync error pulse", serr_n, 1);
        chk(got_n == 0 && end_n == 0, "R3 no data on sync error", got_n + end_n, 0);
        clr_mon();
        pkt_n = 1; pkt[0] = 8'h69;
        send_pkt(0, 0, 0);
        check_bytes("R3 recovery after sync error");
    endtask

    task automatic test_idle_noise();
        clr_mon();
        {dp, dm} = LSE0; repeat (4) @(negedge clk);
        {dp, dm} = LJ;   repeat (30) @(negedge clk);
        {dp, dm} = LSE0; repeat (25) @(negedge clk);
        {dp, dm} = LJ;   repeat (200) @(negedge clk);
        chk(got_n + end_n + ovf_n + serr_n == 0, "R1 idle ignores SE0",
            got_n + end_n + ovf_n + serr_n, 0);
    endtask

    task automatic test_drift(input int d);
        clr_mon();
        pkt_n = NBUF;
        pkt[0] = 8'hC3; pkt[1] = 8'h00; pkt[2] = 8'hFF; pkt[3] = 8'h01;
        pkt[4] = 8'h80; pkt[5] = 8'h55; pkt[6] = 8'hF0; pkt[7] = 8'h3E;
        send_pkt(d, 0, 0);
        check_bytes(d > 0 ? "R9 slow transmitter" : "R9 fast transmitter");
        chk(end_n == 1, "R9 end under drift", end_n, 1);
    endtask

    initial begin
        clr_mon();
        {dp, dm} = LJ;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_idle_noise();
        test_single();
        test_multi();
        test_stuff();
        test_stuff_at_end();
        test_overflow();
        test_sync_err();
        test_drift(1);
        test_drift(-1);
        summary();
        $finish;
    end

endmodule